// File: doc/BRIEF.md
# Block I/O Transfer Sequencer

This block moves bytes between a synchronous memory port and a 16-bit-addressed I/O port, in the way an 8-bit CPU runs its block input and output operations. A byte count register, a low port byte register and a 16-bit memory pointer are loaded beforehand. A start strobe then launches one of eight operations. The operation code selects the direction (port to memory or memory to port), the pointer step (up or down) and whether the operation runs once or repeats.

The count byte does two jobs. It is the transfer counter, and it is also the upper byte of every port address, with the low port byte below it. Input operations store the port byte to memory before the count is decremented. Output operations decrement the count first, so the port write carries the reduced count in its upper address byte.

A repeating operation continues until the count reaches zero. At each iteration boundary it samples an interrupt request. When the request is set, it stops early with a paused pulse and a flag snapshot that marks the pending state. Issuing the same start again resumes the operation from where it stopped.

Top module: `blkio_seq`

## Requirements
- R1: After reset the count, low port byte and pointer read back as zero, busy, done and paused are low, all three flags are zero, and no memory or port strobe is active.
- R2: While idle, a load with select 0 writes the count from ld_data[7:0], select 1 writes the low port byte from ld_data[7:0], and select 2 writes the pointer from ld_data[15:0]; the readback ports show the new value on the next cycle.
- R3: Every port read and port write presents the address {count, low byte}, with the count on bits 15:8.
- R4: The operation code is {repeat, output, down}, one bit each. For an input operation (op[1]=0), the byte read from the port is written to memory at the pointer one cycle after the port read, and the count is decremented only after that store.
- R5: For an output operation (op[1]=1), the memory byte at the pointer is read, the count is decremented, and one cycle later the byte is written to the port at {decremented count, low byte}.
- R6: After each transfer the pointer moves by +1 when op[0]=0 and by -1 when op[0]=1, modulo 2^16.
- R7: A single-step operation (op[2]=0) makes exactly one transfer whatever the count, and raises done for exactly one cycle.
- R8: A repeating operation makes transfers until the count reaches zero; a start with count zero makes 256 transfers.
- R9: Each transfer occupies three cycles (read, write, update). Done or paused is high in the cycle after the last update, so an uninterrupted run of N transfers signals its end 3N+1 cycles after the start edge.
- R10: With the interrupt request high at the end of an iteration of a repeating operation that still has a non-zero count, the block raises paused instead of done and returns to idle, keeping its registers. A second start with the same code completes the remaining transfers.
- R11: flags[0] is set when the count is zero after the last transfer. flags[1] holds bit 7 of the last byte transferred. flags[2] is 1 after a pause and 0 after a completed operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, sampled while idle |
| op | input | 3 | Operation code {repeat, output, down} |
| irq | input | 1 | Interrupt request, sampled at iteration ends |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 2 | Load target: 0 count, 1 low port byte, 2 pointer |
| ld_data | input | 16 | Load value |
| cnt_q | output | 8 | Count register readback |
| lo_q | output | 8 | Low port byte readback |
| ptr_q | output | 16 | Memory pointer readback |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe; data returns next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| io_addr | output | 16 | Port address {count, low byte} |
| io_rd | output | 1 | Port read strobe; data returns next cycle |
| io_wr | output | 1 | Port write strobe |
| io_wdata | output | 8 | Port write data |
| io_rdata | input | 8 | Port read data |
| busy | output | 1 | A transfer sequence is running |
| done | output | 1 | One-cycle pulse when an operation completes |
| paused | output | 1 | One-cycle pulse when an interrupt stops a repeat |
| flags | output | 3 | {pending, sign, zero} snapshot |

## Verification
The read strobe is due one cycle after the start edge, and the matching write one cycle after that. The pointer and count updates follow in the next cycle. Done or paused is due 3N+1 cycles after the start edge for N transfers. The bench drives inputs and samples outputs on falling edges and counts those edges from the start. At each falling edge it checks address and data against its own model of the count, pointer and port address. It compares the edge count at which done or paused appears with 3N+1. It reads the registers and flags only once the run has ended, and confirms on the next falling edge that the end pulse has dropped.

// File: rtl/blkio_pkg.sv
package blkio_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FETCH = 2'd1,
    SQ_STORE = 2'd2,
    SQ_STEP  = 2'd3
  } sq_state_t;

  typedef struct packed {
    logic rpt;
    logic outp;
    logic dec;
  } xfer_op_t;

  localparam logic [1:0] SEL_CNT = 2'd0;
  localparam logic [1:0] SEL_LO  = 2'd1;
  localparam logic [1:0] SEL_PTR = 2'd2;

  localparam int FL_ZERO = 0;
  localparam int FL_SIGN = 1;
  localparam int FL_PEND = 2;
  localparam int FL_W    = 3;
endpackage

// File: rtl/blkio_regs.sv
module blkio_regs
  import blkio_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [1:0]    ld_sel,
  input  logic [PW-1:0] ld_data,
  input  logic          cnt_dec,
  input  logic          ptr_step,
  input  logic          ptr_down,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] lo_q,
  output logic [PW-1:0] ptr_q
);
  logic ld_cnt, ld_lo, ld_ptr;

  assign ld_cnt = ld_en && (ld_sel == SEL_CNT);
  assign ld_lo  = ld_en && (ld_sel == SEL_LO);
  assign ld_ptr = ld_en && (ld_sel == SEL_PTR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ld_cnt) begin
      cnt_q <= ld_data[DW-1:0];
    end else if (cnt_dec) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
    end else if (ld_lo) begin
      lo_q <= ld_data[DW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (ld_ptr) begin
      ptr_q <= ld_data;
    end else if (ptr_step) begin
      ptr_q <= ptr_down ? ptr_q - 1'b1 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/blkio_ctrl.sv
module blkio_ctrl
  import blkio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  xfer_op_t      op_in,
  input  logic          irq,
  input  logic [DW-1:0] cnt_q,
  output sq_state_t     state,
  output xfer_op_t      op_q,
  output logic          cnt_dec,
  output logic          ptr_step,
  output logic          cap_byte,
  output logic          iter_end,
  output logic          zero_next,
  output logic          pause_now,
  output logic          done,
  output logic          paused
);
  logic [DW-1:0] cnt_after;
  logic          more;

  // Output forms already decremented during FETCH; input forms decrement in STEP.
  assign cnt_after = op_q.outp ? cnt_q : cnt_q - 1'b1;
  assign zero_next = (cnt_after == '0);
  assign more      = op_q.rpt && !zero_next;

  assign iter_end  = (state == SQ_STEP);
  assign cap_byte  = (state == SQ_STORE);
  assign ptr_step  = iter_end;
  assign cnt_dec   = ((state == SQ_FETCH) && op_q.outp) || (iter_end && !op_q.outp);
  assign pause_now = iter_end && more && irq;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      op_q   <= '0;
      done   <= 1'b0;
      paused <= 1'b0;
    end else begin
      done   <= 1'b0;
      paused <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (start) begin
            op_q  <= op_in;
            state <= SQ_FETCH;
          end
        end
        SQ_FETCH: state <= SQ_STORE;
        SQ_STORE: state <= SQ_STEP;
        SQ_STEP: begin
          if (more && !irq) begin
            state <= SQ_FETCH;
          end else begin
            state  <= SQ_IDLE;
            paused <= pause_now;
            done   <= !pause_now;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkio_flags.sv
module blkio_flags
  import blkio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_byte,
  input  logic [DW-1:0]   xfer_byte,
  input  logic            iter_end,
  input  logic            zero_next,
  input  logic            pause_now,
  output logic [FL_W-1:0] flags
);
  logic byte_msb;

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_msb <= 1'b0;
    end else if (cap_byte) begin
      byte_msb <= xfer_byte[DW-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (iter_end) begin
      flags[FL_ZERO] <= zero_next;
      flags[FL_SIGN] <= byte_msb;
      flags[FL_PEND] <= pause_now;
    end
  end
endmodule

// File: rtl/blkio_seq.sv
module blkio_seq
  import blkio_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 16,
  localparam int IOW = 2 * DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2:0]     op,
  input  logic           irq,
  input  logic           ld_en,
  input  logic [1:0]     ld_sel,
  input  logic [PW-1:0]  ld_data,
  output logic [DW-1:0]  cnt_q,
  output logic [DW-1:0]  lo_q,
  output logic [PW-1:0]  ptr_q,
  output logic [PW-1:0]  mem_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic [IOW-1:0] io_addr,
  output logic           io_rd,
  output logic           io_wr,
  output logic [DW-1:0]  io_wdata,
  input  logic [DW-1:0]  io_rdata,
  output logic           busy,
  output logic           done,
  output logic           paused,
  output logic [2:0]     flags
);
  sq_state_t state;
  xfer_op_t  op_q;
  logic      cnt_dec, ptr_step, cap_byte, iter_end, zero_next, pause_now;
  logic      in_fetch, in_store;
  logic [DW-1:0] xfer_byte;

  blkio_ctrl #(.DW(DW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op_in     (xfer_op_t'(op)),
    .irq       (irq),
    .cnt_q     (cnt_q),
    .state     (state),
    .op_q      (op_q),
    .cnt_dec   (cnt_dec),
    .ptr_step  (ptr_step),
    .cap_byte  (cap_byte),
    .iter_end  (iter_end),
    .zero_next (zero_next),
    .pause_now (pause_now),
    .done      (done),
    .paused    (paused)
  );

  blkio_regs #(.DW(DW), .PW(PW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .ld_en    (ld_en && (state == SQ_IDLE)),
    .ld_sel   (ld_sel),
    .ld_data  (ld_data),
    .cnt_dec  (cnt_dec),
    .ptr_step (ptr_step),
    .ptr_down (op_q.dec),
    .cnt_q    (cnt_q),
    .lo_q     (lo_q),
    .ptr_q    (ptr_q)
  );

  assign xfer_byte = op_q.outp ? mem_rdata : io_rdata;

  blkio_flags #(.DW(DW)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .cap_byte  (cap_byte),
    .xfer_byte (xfer_byte),
    .iter_end  (iter_end),
    .zero_next (zero_next),
    .pause_now (pause_now),
    .flags     (flags)
  );

  assign in_fetch  = (state == SQ_FETCH);
  assign in_store  = (state == SQ_STORE);
  assign busy      = (state != SQ_IDLE);

  assign mem_addr  = ptr_q;
  assign mem_rd    = in_fetch && op_q.outp;
  assign mem_wr    = in_store && !op_q.outp;
  assign mem_wdata = io_rdata;

  assign io_addr   = {cnt_q, lo_q};
  assign io_rd     = in_fetch && !op_q.outp;
  assign io_wr     = in_store && op_q.outp;
  assign io_wdata  = mem_rdata;
endmodule

// File: rtl/blkio_seq_chk.sv
module blkio_seq_chk #(
  parameter int DW = 8,
  parameter int PW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            ld_en,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            io_rd,
  input logic            io_wr,
  input logic [2*DW-1:0] io_addr,
  input logic [DW-1:0]   cnt_q,
  input logic [DW-1:0]   lo_q,
  input logic            busy,
  input logic            done,
  input logic            paused
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(mem_rd || mem_wr || io_rd || io_wr));

  // R3
  io_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd || io_wr) |-> io_addr == {cnt_q, lo_q});

  // R4
  in_order_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(io_rd));

  // R5
  out_order_chk: assert property (@(posedge clk) disable iff (rst)
    io_wr |-> $past(mem_rd));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr}));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  end_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && paused));

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ld_en) && (cnt_q != $past(cnt_q)))
      |-> (cnt_q == DW'($past(cnt_q) - 1'b1)));
endmodule

bind blkio_seq blkio_seq_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ld_en   (ld_en),
  .mem_rd  (mem_rd),
  .mem_wr  (mem_wr),
  .io_rd   (io_rd),
  .io_wr   (io_wr),
  .io_addr (io_addr),
  .cnt_q   (cnt_q),
  .lo_q    (lo_q),
  .busy    (busy),
  .done    (done),
  .paused  (paused)
);

// File: tb/tb_blkio_seq.sv
module tb_blkio_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic        irq = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [15:0] ld_data = '0;
  logic [7:0]  cnt_q, lo_q;
  logic [15:0] ptr_q, mem_addr, io_addr;
  logic        mem_rd, mem_wr, io_rd, io_wr, busy, done, paused;
  logic [7:0]  mem_wdata, io_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  io_rdata = '0;
  logic [2:0]  flags;

  int total = 0;
  int bad = 0;

  logic [7:0]  mb, mc;
  logic [15:0] mhl;
  logic        ms;

  always #(CLK_PERIOD / 2) clk = ~clk;

  blkio_seq dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .irq(irq),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .cnt_q(cnt_q), .lo_q(lo_q), .ptr_q(ptr_q),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .busy(busy), .done(done), .paused(paused), .flags(flags)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return (a[7:0] + 8'(a[15:8] * 3)) ^ 8'h3C;
  endfunction

  function automatic logic [7:0] io_byte(input logic [15:0] a);
    return a[15:8] ^ {a[3:0], a[7:4]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    mem_rdata <= mem_byte(mem_addr);
    io_rdata  <= io_byte(io_addr);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  task automatic load(input logic [7:0] b, input logic [7:0] c, input logic [15:0] hl);
    ld_en = 1'b1; ld_sel = 2'd0; ld_data = {8'h00, b};
    @(negedge clk); ld_sel = 2'd1; ld_data = {8'h00, c};
    @(negedge clk); ld_sel = 2'd2; ld_data = hl;
    @(negedge clk); ld_en = 1'b0;
    mb = b; mc = c; mhl = hl;
  endtask

  // R7 R8 R9 R10 R11 checked per run
  task automatic run(input logic [2:0] code, input int exp_n, input bit exp_pause);
    int n = 0;
    int cyc = 0;
    bit fin = 0;
    logic [7:0] expd = '0;
    op = code;
    start = 1'b1;
    while (!fin && cyc < 2000) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (io_rd) begin
        chk(io_addr == {mb, mc}, "R3", "input port address", io_addr, {mb, mc});
        expd = io_byte(io_addr);
      end
      if (mem_rd) begin
        chk(mem_addr == mhl, "R5", "output memory read address", mem_addr, mhl);
        expd = mem_byte(mhl);
      end
      if (mem_wr) begin
        chk(mem_addr == mhl && mem_wdata == expd, "R4", "store addr/data",
            {mem_addr, mem_wdata}, {mhl, expd});
        chk(cnt_q == mb, "R4", "count not yet decremented at store", cnt_q, mb);
        ms = expd[7]; mb = mb - 1'b1; n++;
        mhl = code[0] ? mhl - 1'b1 : mhl + 1'b1;
      end
      if (io_wr) begin
        mb = mb - 1'b1;
        chk(io_addr == {mb, mc} && io_wdata == expd, "R5", "port write addr/data",
            {io_addr, io_wdata}, {mb, mc, expd});
        ms = expd[7]; n++;
        mhl = code[0] ? mhl - 1'b1 : mhl + 1'b1;
      end
      if (done || paused) fin = 1;
    end
    chk(fin, "R9", "run ended", 32'(fin), 1);
    chk(paused == exp_pause && done == !exp_pause, "R10", "end kind",
        {done, paused}, {!exp_pause, exp_pause});
    chk(n == exp_n, "R8", "transfer count", n, exp_n);
    chk(cyc == 3 * exp_n + 1, "R9", "end cycle", cyc, 3 * exp_n + 1);
    chk(ptr_q == mhl, "R6", "pointer", ptr_q, mhl);
    chk(cnt_q == mb, "R8", "count", cnt_q, mb);
    chk(flags == {exp_pause, ms, mb == 8'h00}, "R11", "flags", flags,
        {exp_pause, ms, mb == 8'h00});
    @(negedge clk);
    chk(!done && !paused && !busy, "R7", "end pulse one cycle",
        {busy, done, paused}, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cnt_q == 0 && lo_q == 0 && ptr_q == 0, "R1", "regs after reset",
        {cnt_q, lo_q, ptr_q}, 0);
    chk(!busy && !done && !paused && flags == 0, "R1", "status after reset",
        {busy, done, paused, flags}, 0);
    chk(!(mem_rd || mem_wr || io_rd || io_wr), "R1", "strobes after reset",
        {mem_rd, mem_wr, io_rd, io_wr}, 0);

    // R2 load and readback
    load(8'h12, 8'h34, 16'hBEEF);
    chk(cnt_q == 8'h12 && lo_q == 8'h34 && ptr_q == 16'hBEEF, "R2", "readback",
        {cnt_q, lo_q, ptr_q}, {8'h12, 8'h34, 16'hBEEF});

    // R7 single input, count 1 -> zero flag
    load(8'h01, 8'h7F, 16'h1000);
    run(3'b000, 1, 0);
    // R7 R6 single output down from 0000, count 5 -> one transfer only
    load(8'h05, 8'hA0, 16'h0000);
    run(3'b011, 1, 0);
    // R6 R8 repeat input up across FFFF
    load(8'h04, 8'h11, 16'hFFFE);
    run(3'b100, 4, 0);
    // R8 repeat output starting at count zero -> 256 transfers
    load(8'h00, 8'hC3, 16'h4000);
    run(3'b110, 256, 0);
    // R10 pause then resume
    load(8'h03, 8'h22, 16'h2000);
    irq = 1'b1;
    run(3'b110, 1, 1);
    irq = 1'b0;
    run(3'b110, 2, 0);
    // random mix
    for (int i = 0; i < 30; i++) begin
      logic [2:0] rc;
      logic [7:0] rb;
      int en;
      rc = 3'($urandom % 8);
      rb = rc[2] ? 8'(1 + $urandom % 6) : 8'($urandom % 256);
      load(rb, 8'($urandom), 16'($urandom));
      en = rc[2] ? int'(rb) : 1;
      run(rc, en, 0);
    end
    finish_up();
  end
endmodule